// File: doc/BRIEF.md
# Synchronous SYN-Hunt Character Receiver

This block is the receive half of a byte-oriented synchronous link. It takes one serial bit per `bitStrobe` pulse, least significant bit first. After the receiver is enabled, it slides a window over the incoming bits until the window equals a programmed SYN1 pattern. In double-SYN mode it then checks that the next whole character equals SYN2 before it declares character sync. From that point it cuts the stream into characters of 5 to 8 data bits, each followed by a parity bit when parity is on, and places every character it keeps in a single holding register that has a ready flag.

In transparent mode a programmed DLE character works as an escape. A DLE followed by SYN1 is line fill and sets SYN-detect again. A DLE followed by anything other than SYN2 or DLE raises the DLE-detect flag, which shares its status bit with the parity error. Optional stripping removes fill and escape characters before they reach the holding register. It never changes how the status flags are set. A jam-sync mode replaces the hunt with an external sync pulse.

All configuration inputs are static while the receiver is enabled. `bitStrobe` pulses must be at least two clock cycles apart.

Top module: `synHuntRx`

## Requirements
- R1: A 0-to-1 change of `rxEn` starts a fresh hunt. While `rxEn` is low, `rxReady`, `synDetect` and `errFlag` are held at 0.
- R2: In hunt, the last L received bits are compared with the low L bits of `syn1Pat` after every bit, where L = 5 + `charLen`. Bits arrive LSB first. In single-SYN mode (`singleSyn`=1) a match gives sync and sets `synDetect`. The SYN characters that establish sync are never loaded into the holding register.
- R3: In double-SYN mode the first character after the SYN1 match must equal SYN2 to give sync. Otherwise the hunt restarts, so the sequence SYN1, SYN1, SYN2 does not give sync.
- R4: In sync, each kept character is loaded into `rxData` and `rxReady` goes to 1. With `parityEn`=1 a frame is L data bits followed by one parity bit. The parity bit that follows the matched SYN1 is skipped.
- R5: Loading a character while `rxReady` is still 1 (and no `dataRd` in the same cycle) sets `overrun`.
- R6: `charLen` selects 5, 6, 7 or 8 data bits for codes 0 to 3. Bits of `rxData` above L read as 0.
- R7: With `parityEn`=1, `errFlag` is set for a character whose data bits plus parity bit hold an odd number of ones (`parityOdd`=0) or an even number (`parityOdd`=1). A clean loaded character clears it.
- R8: In non-transparent mode with `stripEn`=1, single-SYN mode drops every SYN1. Double-SYN mode drops every SYN1, and drops a SYN2 only when it directly follows SYN1.
- R9: In transparent mode with `stripEn`=1, an unpaired DLE is dropped and a SYN1 directly after it is dropped. Of a DLE-DLE pair only the first DLE is dropped.
- R10: In transparent mode with parity off, `errFlag` is set when an unpaired DLE is followed by a character that is neither SYN2 nor DLE. A DLE-DLE pair does not arm a following character. The next loaded character that does not meet the condition clears the flag.
- R11: In sync, `synDetect` is set again by SYN1 (single), by SYN1 then SYN2 (double) or by DLE then SYN1 (transparent). A `statusRd` pulse clears it.
- R12: Stripping changes only what is loaded. `synDetect` and `errFlag` are set as if stripping were off.
- R13: With `jamSyncEn`=1 the internal SYN hunt is disabled. A rising edge on `jamSync` gives sync, and assembly starts at the next `bitStrobe`. `synDetect` is set and stays set until `statusRd`.
- R14: `dataRd` clears `rxReady`. `errReset` clears `overrun` and `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEn | input | 1 | Receiver enable |
| rxBit | input | 1 | Serial data bit |
| bitStrobe | input | 1 | One-cycle pulse that marks a valid `rxBit` |
| charLen | input | 2 | Data bits per character minus 5 |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| singleSyn | input | 1 | 1 = single-SYN, 0 = double-SYN |
| transparent | input | 1 | DLE escape mode |
| stripEn | input | 1 | Drop SYN/DLE fill characters |
| jamSyncEn | input | 1 | External sync replaces the hunt |
| jamSync | input | 1 | External sync; acts on its rising edge |
| syn1Pat | input | 8 | First sync pattern |
| syn2Pat | input | 8 | Second sync pattern |
| dlePat | input | 8 | Escape pattern |
| statusRd | input | 1 | Status read pulse |
| dataRd | input | 1 | Holding register read pulse |
| errReset | input | 1 | Error flag reset pulse |
| rxData | output | 8 | Holding register |
| rxReady | output | 1 | Holding register full |
| synDetect | output | 1 | SYN detect status |
| errFlag | output | 1 | Parity error or DLE detect |
| overrun | output | 1 | Overrun status |

## Verification
The hunt is given a SYN1 that arrives after unaligned noise bits, which shows that the window really slides bit by bit. It is also given SYN1-SYN1-SYN2 and then SYN1-SYN2, which separates a correct double-SYN confirmation from one that keeps looking for SYN2 after a repeated SYN1. Transparent streams of DLE followed by data, DLE-SYN1 and DLE-DLE-data, each run with stripping off and then on, separate the escape pairing from plain DLE matching and show that stripping leaves the flags alone. Random characters with random lengths, parity senses and deliberately wrong parity bits check the framing, the zeroing of unused bits and the parity sense. A jam-sync run shows that a SYN1 is ignored until the external edge arrives.

// File: rtl/synHuntRxPkg.sv
package synHuntRxPkg;
  localparam int MIN_LEN = 5;
  localparam int MAX_LEN = 8;
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_CONFIRM, ST_SYNC} rxState_t;

  typedef struct packed {
    logic idle;     // receiver disabled
    logic hunt;     // sliding SYN1 search active
    logic restart;  // clear framing state
    logic huntGo;   // accepted SYN1 match
    logic load;     // move assembled character to holding register
    logic setSyn;   // set SYN detect
    logic setErr;   // set parity/DLE flag
  } rxCtl_t;
endpackage

// File: rtl/rxDatapath.sv
module rxDatapath
  import synHuntRxPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rxCtl_t               ctl,
  input  logic                 rxBit,
  input  logic                 bitStrobe,
  input  logic [1:0]           charLen,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic [MAX_LEN-1:0]   syn1Pat,
  input  logic [MAX_LEN-1:0]   syn2Pat,
  input  logic [MAX_LEN-1:0]   dlePat,
  input  logic                 statusRd,
  input  logic                 dataRd,
  input  logic                 errReset,
  output logic                 huntMatch,
  output logic                 charDone,
  output logic                 isSyn1,
  output logic                 isSyn2,
  output logic                 isDle,
  output logic                 parErr,
  output logic [MAX_LEN-1:0]   rxData,
  output logic                 rxReady,
  output logic                 synDetect,
  output logic                 errFlag,
  output logic                 overrun
);
  logic [CNT_W-1:0]   lenBits, shiftAmt, fillQ, cntQ;
  logic [MAX_LEN-1:0] mask, shiftQ, shiftNext, window, charQ;
  logic               parQ, skipQ, doneQ;

  assign lenBits   = CNT_W'(MIN_LEN) + CNT_W'(charLen);
  assign shiftAmt  = CNT_W'(MAX_LEN) - lenBits;
  assign mask      = {MAX_LEN{1'b1}} >> shiftAmt;
  assign shiftNext = {rxBit, shiftQ[MAX_LEN-1:1]};
  assign window    = shiftNext >> shiftAmt;

  assign huntMatch = ctl.hunt && bitStrobe && (fillQ >= lenBits - 1'b1)
                     && (window == (syn1Pat & mask));
  assign charDone  = doneQ;
  assign isSyn1    = (charQ == (syn1Pat & mask));
  assign isSyn2    = (charQ == (syn2Pat & mask));
  assign isDle     = (charQ == (dlePat & mask));
  assign parErr    = parityEn && (((^charQ) ^ parQ) != parityOdd);

  // framing: hunt shifter and character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0; charQ <= '0; fillQ <= '0; cntQ <= '0;
      parQ <= 1'b0; skipQ <= 1'b0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.idle || ctl.restart) begin
        shiftQ <= '0; fillQ <= '0; cntQ <= '0; skipQ <= 1'b0;
      end else if (ctl.hunt) begin
        if (bitStrobe) begin
          shiftQ <= shiftNext;
          if (fillQ < CNT_W'(MAX_LEN)) fillQ <= fillQ + 1'b1;
          if (ctl.huntGo) begin
            skipQ <= parityEn;
            cntQ  <= '0;
          end
        end
      end else if (bitStrobe) begin
        if (skipQ) begin
          skipQ <= 1'b0;
        end else if (cntQ < lenBits) begin
          shiftQ <= shiftNext;
          if ((cntQ == lenBits - 1'b1) && !parityEn) begin
            charQ <= window;
            doneQ <= 1'b1;
            cntQ  <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end else begin
          parQ  <= rxBit;
          charQ <= shiftQ >> shiftAmt;
          doneQ <= 1'b1;
          cntQ  <= '0;
        end
      end
    end
  end

  // holding register and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0; rxReady <= 1'b0; synDetect <= 1'b0;
      errFlag <= 1'b0; overrun <= 1'b0;
    end else begin
      if (ctl.load) rxData <= charQ;

      if (ctl.idle)          rxReady <= 1'b0;
      else if (ctl.load)     rxReady <= 1'b1;
      else if (dataRd)       rxReady <= 1'b0;

      if (ctl.load && rxReady && !dataRd) overrun <= 1'b1;
      else if (errReset)                  overrun <= 1'b0;

      if (ctl.idle)          synDetect <= 1'b0;
      else if (ctl.setSyn)   synDetect <= 1'b1;
      else if (statusRd)     synDetect <= 1'b0;

      if (ctl.idle)          errFlag <= 1'b0;
      else if (ctl.setErr)   errFlag <= 1'b1;
      else if (errReset)     errFlag <= 1'b0;
      else if (ctl.load)     errFlag <= 1'b0;
    end
  end

  a_r5_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxReady));
  a_r6_high_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> ((rxData & ~mask) == '0));
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> (!rxReady && !synDetect && !errFlag));
  a_r4_done_is_pulse: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> !charDone);
  a_r14_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !ctl.load && !ctl.idle) |=> !rxReady);
endmodule

// File: rtl/rxControl.sv
module rxControl
  import synHuntRxPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEn,
  input  logic   singleSyn,
  input  logic   transparent,
  input  logic   stripEn,
  input  logic   parityEn,
  input  logic   jamSyncEn,
  input  logic   jamSync,
  input  logic   huntMatch,
  input  logic   charDone,
  input  logic   isSyn1,
  input  logic   isSyn2,
  input  logic   isDle,
  input  logic   parErr,
  output rxCtl_t ctl
);
  rxState_t state, stateNext;
  logic enQ, jamQ, armedQ, prevSyn1Q;
  logic enRise, jamRise, huntGo, armedNow, synEv, dleEv, errEv, drop, inSyncChar;

  assign enRise     = rxEn && !enQ;
  assign jamRise    = jamSyncEn && jamSync && !jamQ && rxEn;
  assign huntGo     = (state == ST_HUNT) && huntMatch && !jamSyncEn;
  assign inSyncChar = (state == ST_SYNC) && charDone;
  assign armedNow   = transparent && isDle && !armedQ;

  always_comb begin
    if (transparent) begin
      synEv = !jamSyncEn && armedQ && isSyn1;
      dleEv = !parityEn && armedQ && !isSyn2 && !isDle;
      drop  = stripEn && (armedNow || (armedQ && isSyn1));
    end else begin
      synEv = !jamSyncEn && (singleSyn ? isSyn1 : (prevSyn1Q && isSyn2));
      dleEv = 1'b0;
      drop  = stripEn && (isSyn1 || (!singleSyn && prevSyn1Q && isSyn2));
    end
    errEv = (transparent && !parityEn) ? dleEv : parErr;
  end

  always_comb begin
    ctl.idle    = !rxEn;
    ctl.hunt    = (state == ST_HUNT);
    ctl.huntGo  = huntGo;
    ctl.restart = enRise || jamRise || ((state == ST_CONFIRM) && charDone && !isSyn2);
    ctl.load    = inSyncChar && !drop && !jamRise;
    ctl.setSyn  = (huntGo && singleSyn) || ((state == ST_CONFIRM) && charDone && isSyn2)
                  || jamRise || (inSyncChar && synEv);
    ctl.setErr  = inSyncChar && errEv;
  end

  always_comb begin
    stateNext = state;
    if (!rxEn)         stateNext = ST_IDLE;
    else if (jamRise)  stateNext = ST_SYNC;
    else begin
      case (state)
        ST_IDLE:    stateNext = ST_HUNT;
        ST_HUNT:    if (huntGo) stateNext = singleSyn ? ST_SYNC : ST_CONFIRM;
        ST_CONFIRM: if (charDone) stateNext = isSyn2 ? ST_SYNC : ST_HUNT;
        default:    stateNext = ST_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; enQ <= 1'b0; jamQ <= 1'b0;
      armedQ <= 1'b0; prevSyn1Q <= 1'b0;
    end else begin
      state <= stateNext;
      enQ   <= rxEn;
      jamQ  <= jamSync;
      if (state != ST_SYNC || jamRise) begin
        armedQ <= 1'b0; prevSyn1Q <= 1'b0;
      end else if (charDone) begin
        armedQ    <= armedNow;
        prevSyn1Q <= isSyn1;
      end
    end
  end

  a_r3_confirm_only_double: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM) |-> !singleSyn);
  a_r13_jam_no_confirm: assert property (@(posedge clk) disable iff (!rstN)
    (jamSyncEn && state == ST_HUNT) |=> (state != ST_CONFIRM));
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> (state == ST_IDLE));
endmodule

// File: rtl/synHuntRx.sv
module synHuntRx
  import synHuntRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic       rxBit,
  input  logic       bitStrobe,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       singleSyn,
  input  logic       transparent,
  input  logic       stripEn,
  input  logic       jamSyncEn,
  input  logic       jamSync,
  input  logic [7:0] syn1Pat,
  input  logic [7:0] syn2Pat,
  input  logic [7:0] dlePat,
  input  logic       statusRd,
  input  logic       dataRd,
  input  logic       errReset,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       synDetect,
  output logic       errFlag,
  output logic       overrun
);
  rxCtl_t ctl;
  logic huntMatch, charDone, isSyn1, isSyn2, isDle, parErr;

  rxControl uCtl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .singleSyn(singleSyn),
    .transparent(transparent), .stripEn(stripEn), .parityEn(parityEn),
    .jamSyncEn(jamSyncEn), .jamSync(jamSync), .huntMatch(huntMatch),
    .charDone(charDone), .isSyn1(isSyn1), .isSyn2(isSyn2), .isDle(isDle),
    .parErr(parErr), .ctl(ctl)
  );

  rxDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .bitStrobe(bitStrobe),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .syn1Pat(syn1Pat), .syn2Pat(syn2Pat), .dlePat(dlePat),
    .statusRd(statusRd), .dataRd(dataRd), .errReset(errReset),
    .huntMatch(huntMatch), .charDone(charDone), .isSyn1(isSyn1),
    .isSyn2(isSyn2), .isDle(isDle), .parErr(parErr), .rxData(rxData),
    .rxReady(rxReady), .synDetect(synDetect), .errFlag(errFlag), .overrun(overrun)
  );
endmodule

// File: tb/synHuntRx_test.sv
module synHuntRx_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxEn = 0, rxBit = 0, bitStrobe = 0;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 0, parityOdd = 0, singleSyn = 1, transparent = 0, stripEn = 0;
  logic jamSyncEn = 0, jamSync = 0, statusRd = 0, dataRd = 0, errReset = 0;
  logic [7:0] syn1Pat = 8'h16, syn2Pat = 8'h3C, dlePat = 8'h10;
  logic [7:0] rxData;
  logic rxReady, synDetect, errFlag, overrun;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synHuntRx uut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxBit(rxBit), .bitStrobe(bitStrobe),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .singleSyn(singleSyn), .transparent(transparent), .stripEn(stripEn),
    .jamSyncEn(jamSyncEn), .jamSync(jamSync), .syn1Pat(syn1Pat),
    .syn2Pat(syn2Pat), .dlePat(dlePat), .statusRd(statusRd), .dataRd(dataRd),
    .errReset(errReset), .rxData(rxData), .rxReady(rxReady),
    .synDetect(synDetect), .errFlag(errFlag), .overrun(overrun)
  );

  function automatic int curLen();
    return 5 + int'(charLen);
  endfunction
  function automatic logic [7:0] maskOf();
    return 8'hFF >> (8 - curLen());
  endfunction
  function automatic logic parBit(input logic [7:0] c);
    return (^(c & maskOf())) ^ parityOdd;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask
  task automatic sendBit(input logic b);
    @(negedge clk); rxBit = b; bitStrobe = 1;
    @(negedge clk); bitStrobe = 0;
  endtask
  task automatic sendChar(input logic [7:0] c, input bit badPar = 0);
    for (int i = 0; i < curLen(); i++) sendBit(c[i]);
    if (parityEn) sendBit(parBit(c) ^ badPar);
    tick(); tick();
  endtask
  task automatic pulseStatus();
    @(negedge clk); statusRd = 1; @(negedge clk); statusRd = 0;
  endtask
  task automatic pulseData();
    @(negedge clk); dataRd = 1; @(negedge clk); dataRd = 0;
  endtask
  task automatic pulseErr();
    @(negedge clk); errReset = 1; @(negedge clk); errReset = 0;
  endtask
  task automatic rxOff();
    @(negedge clk); rxEn = 0; tick(); tick();
  endtask
  task automatic rxOn();
    @(negedge clk); rxEn = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(); tick(); rstN = 1; tick();
    check("R1 reset ready", rxReady, 0);
    check("R1 reset syn", synDetect, 0);
    check("R1 reset overrun", overrun, 0);
    check("R1 reset err", errFlag, 0);

    // single SYN, unaligned noise first
    rxOn();
    sendBit(1); sendBit(0); sendBit(1);
    sendChar(syn1Pat);
    check("R2 hunt sync", synDetect, 1);
    check("R2 sync char not loaded", rxReady, 0);
    pulseStatus();
    check("R11 status read clears", synDetect, 0);
    sendChar(8'hA5);
    check("R4 ready", rxReady, 1);
    check("R4 data", rxData, 8'hA5);
    sendChar(8'h5A);
    check("R5 overrun", overrun, 1);
    check("R5 newest data", rxData, 8'h5A);
    pulseData();
    check("R14 read clears ready", rxReady, 0);
    pulseErr();
    check("R14 reset clears overrun", overrun, 0);
    sendChar(syn1Pat);
    check("R11 syn in stream", synDetect, 1);
    check("R4 syn loaded when not stripping", rxData, syn1Pat);
    pulseData(); pulseStatus();
    stripEn = 1;
    sendChar(syn1Pat);
    check("R8 single strip drops SYN1", rxReady, 0);
    check("R12 strip keeps syn detect", synDetect, 1);
    sendChar(8'h41);
    check("R8 data after strip", rxData, 8'h41);
    pulseData();
    rxOff();
    check("R1 disable clears syn", synDetect, 0);

    // double SYN
    singleSyn = 0; stripEn = 0;
    rxOn();
    sendChar(syn1Pat); sendChar(syn1Pat); sendChar(syn2Pat);
    check("R3 SYN1 SYN1 SYN2 rejected", synDetect, 0);
    check("R3 nothing loaded", rxReady, 0);
    sendChar(syn1Pat); sendChar(syn2Pat);
    check("R3 SYN1 SYN2 syncs", synDetect, 1);
    check("R2 sync pair not loaded", rxReady, 0);
    pulseStatus();
    stripEn = 1;
    sendChar(syn1Pat);
    check("R8 double strip SYN1", rxReady, 0);
    sendChar(syn2Pat);
    check("R8 double strip SYN2 after SYN1", rxReady, 0);
    check("R12 double syn detect while stripping", synDetect, 1);
    sendChar(syn2Pat);
    check("R8 lone SYN2 kept", rxReady, 1);
    check("R8 lone SYN2 data", rxData, syn2Pat);
    pulseData();
    rxOff();

    // transparent
    singleSyn = 1; stripEn = 0; transparent = 1;
    rxOn();
    sendChar(syn1Pat);
    pulseStatus();
    sendChar(dlePat); pulseData();
    sendChar(8'h41);
    check("R10 DLE then data flags", errFlag, 1);
    check("R10 data loaded", rxData, 8'h41);
    pulseData();
    sendChar(8'h42);
    check("R10 next load clears", errFlag, 0);
    pulseData();
    sendChar(dlePat); pulseData();
    sendChar(syn1Pat);
    check("R11 DLE SYN1 sets syn", synDetect, 1);
    pulseData(); pulseErr();
    check("R14 reset clears err", errFlag, 0);
    pulseStatus();
    sendChar(dlePat); pulseData(); sendChar(dlePat); pulseData();
    sendChar(8'h43);
    check("R10 DLE pair does not arm", errFlag, 0);
    pulseData();
    stripEn = 1;
    sendChar(dlePat);
    check("R9 lone DLE dropped", rxReady, 0);
    sendChar(syn1Pat);
    check("R9 SYN1 after DLE dropped", rxReady, 0);
    check("R12 DLE SYN1 syn with strip", synDetect, 1);
    pulseStatus();
    sendChar(dlePat); sendChar(dlePat);
    check("R9 second of pair kept", rxReady, 1);
    check("R9 pair data", rxData, dlePat);
    pulseData();
    sendChar(dlePat); sendChar(8'h44);
    check("R12 DLE detect with strip", errFlag, 1);
    check("R9 data after DLE", rxData, 8'h44);
    pulseData(); pulseErr();
    rxOff();

    // parity, 7-bit
    transparent = 0; stripEn = 0; parityEn = 1; parityOdd = 0; charLen = 2'd2;
    rxOn();
    sendChar(syn1Pat);
    check("R4 sync with parity", synDetect, 1);
    sendChar(8'h55);
    check("R4 parity frame data", rxData, 8'h55);
    check("R7 good parity", errFlag, 0);
    pulseData();
    sendChar(8'h2A, 1);
    check("R7 bad parity", errFlag, 1);
    pulseData(); pulseErr();
    rxOff();

    // random framing
    for (int k = 0; k < 8; k++) begin
      charLen = 2'($urandom_range(0, 3));
      parityEn = 1'($urandom_range(0, 1));
      parityOdd = 1'($urandom_range(0, 1));
      rxOn();
      sendChar(syn1Pat);
      for (int j = 0; j < 10; j++) begin
        logic [7:0] c;
        bit bad;
        c = 8'($urandom);
        bad = parityEn && ($urandom_range(0, 3) == 0);
        sendChar(c, bad);
        check("R6 random data", rxData, c & maskOf());
        check("R7 random parity", errFlag, bad);
        pulseData();
      end
      rxOff();
    end

    // jam sync
    charLen = 2'd3; parityEn = 0; jamSyncEn = 1;
    rxOn();
    sendChar(syn1Pat);
    check("R13 hunt disabled", synDetect, 0);
    @(negedge clk); jamSync = 1; tick(); tick(); jamSync = 0;
    check("R13 jam sets syn", synDetect, 1);
    sendChar(8'h77);
    check("R13 assembly after jam", rxData, 8'h77);
    check("R13 syn held", synDetect, 1);
    pulseData(); pulseStatus();
    sendChar(syn1Pat);
    check("R13 no internal syn detect", synDetect, 0);
    rxOff();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule